// File: doc/BRIEF.md
# Four-Tap Serial-MAC FIR Filter

This block computes one output of a four-tap finite impulse response filter per call, using a single signed multiplier and one accumulator. A call starts with a one-cycle `start` pulse. The caller presents a new sample on `sampleIn` and the four coefficients on `coefIn`. It holds both steady until `done` rises.

Inside a call the controller first clears the accumulator. It then visits the taps one per cycle, from index 3 down to index 0. At a tap with index greater than zero, the older delay entry moves up one place, and the moved value times that tap's coefficient is added to the sum. At tap 0 the new sample times coefficient 0 is added, and the sample enters delay entry 0. After the last tap, the sum is copied to the output register and a one-cycle `done`/`outValid` strobe is raised.

The delay line is never cleared between calls, so successive calls form a continuous filter over the stream of samples.

Top module: `fir4_mac`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drives `done`, `outValid` and `result` to zero, and clears the delay line. The first call after reset therefore returns sampleIn*c0 only.
- R2: With `start` accepted at clock edge k, `done` and `outValid` are high in the cycle after edge k+6 and low in the cycle after edge k+7. They stay low in every cycle of the call before that.
- R3: For a call with new sample x and previous samples p1, p2, p3 (most recent first), `result` equals the signed sum x*c0 + p1*c1 + p2*c2 + p3*c3. Coefficient ci is the two's-complement field `coefIn[i*COEF_W +: COEF_W]`, and samples are two's-complement.
- R4: The delay line keeps its contents across any number of idle cycles between calls. A later call's result still uses the three samples of the preceding calls.
- R5: A `start` pulse that arrives while a call is in progress is ignored. It produces no extra `done` and does not shift the delay line.
- R6: The accumulator starts every call from zero, so a result never carries any part of a previous call's sum.
- R7: `result` keeps its value between the capture of one call and the capture of the next.
- R8: `result` is `DATA_W+COEF_W+2` bits wide and signed, and holds the exact sum even when every sample and coefficient is the most negative value.
- R9: `done` and `outValid` are asserted in exactly the same cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a call; ignored unless idle |
| sampleIn | input | DATA_W | New signed input sample, held during the call |
| coefIn | input | 4*COEF_W | Four signed coefficients, tap i at bits i*COEF_W |
| done | output | 1 | One-cycle end-of-call pulse |
| outValid | output | 1 | Result strobe, same cycles as done |
| result | output | DATA_W+COEF_W+2 | Signed filter output, held between calls |

## Verification
The sweeps drive many samples through four coefficient sets that include both extremes. The bench checks every result against an arithmetic model of the delay line. A design that used the wrong delay entry at a tap, or shifted the line in the wrong order, would return sums built from the wrong samples. A design that forgot to clear the accumulator would grow its result from call to call. The bench also raises `start` in the middle of calls and leaves long idle gaps between calls. A design that restarted or shifted on a busy start would show an early or doubled `done`, and the following results would come from a shifted-twice line. An all-most-negative input stream catches a sum too narrow to hold the largest positive total.

// File: rtl/fir_pkg.sv
package fir_pkg;
  localparam int TAPS  = 4;
  localparam int IDX_W = $clog2(TAPS);

  typedef struct packed {
    logic             accClear;
    logic             tapStep;
    logic [IDX_W-1:0] tapIdx;
    logic             capture;
  } ctrl_t;
endpackage

// File: rtl/fir_ctrl.sv
module fir_ctrl
  import fir_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  start,
  output ctrl_t ctrl
);
  typedef enum logic [1:0] {S_IDLE, S_START, S_LOOP, S_FINISH} state_t;

  state_t           state;
  logic [IDX_W-1:0] tapIdx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      tapIdx <= '0;
    end else begin
      case (state)
        S_IDLE:   if (start) state <= S_START;
        S_START: begin
          state  <= S_LOOP;
          tapIdx <= IDX_W'(TAPS - 1);
        end
        S_LOOP: begin
          if (tapIdx == '0) state <= S_FINISH;
          else              tapIdx <= tapIdx - 1'b1;
        end
        default:  state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl          = '0;
    ctrl.accClear = (state == S_START);
    ctrl.tapStep  = (state == S_LOOP);
    ctrl.tapIdx   = tapIdx;
    ctrl.capture  = (state == S_FINISH);
  end

  AST_TAP_DESCEND: assert property (@(posedge clk) disable iff (rst)
    (state == S_LOOP && tapIdx != '0) |=> (state == S_LOOP && tapIdx == $past(tapIdx) - 1'b1)); // R2
  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE) |=> (state != S_START)); // R5
endmodule

// File: rtl/fir_datapath.sv
module fir_datapath
  import fir_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  localparam int PROD_W = DATA_W + COEF_W,
  localparam int ACC_W  = PROD_W + 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  ctrl_t                  ctrl,
  input  logic [DATA_W-1:0]      sampleIn,
  input  logic [TAPS*COEF_W-1:0] coefIn,
  output logic                   outValid,
  output logic [ACC_W-1:0]       result
);
  logic [TAPS-1:0][DATA_W-1:0] dly;
  logic [ACC_W-1:0]            acc;
  logic signed [DATA_W-1:0]    opSample;
  logic signed [COEF_W-1:0]    opCoef;
  logic signed [PROD_W-1:0]    prod;
  logic [IDX_W-1:0]            prevIdx;

  always_comb begin
    prevIdx  = ctrl.tapIdx - 1'b1;
    opSample = (ctrl.tapIdx == '0) ? $signed(sampleIn) : $signed(dly[prevIdx]);
    opCoef   = $signed(coefIn[ctrl.tapIdx*COEF_W +: COEF_W]);
    prod     = opSample * opCoef;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (ctrl.accClear) begin
      acc <= '0;
    end else if (ctrl.tapStep) begin
      acc <= acc + {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < TAPS; gi++) begin : g_dly
      always_ff @(posedge clk) begin
        if (rst) begin
          dly[gi] <= '0;
        end else if (ctrl.tapStep && ctrl.tapIdx == IDX_W'(gi)) begin
          if (gi == 0) dly[gi] <= sampleIn;
          else         dly[gi] <= dly[(gi == 0) ? 0 : gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      result   <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= ctrl.capture;
      if (ctrl.capture) result <= acc;
    end
  end

  AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (rst)
    ctrl.accClear |=> (acc == '0)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid); // R2
  AST_DLY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctrl.tapStep |=> $stable(dly)); // R4
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctrl.capture |=> $stable(result)); // R7
endmodule

// File: rtl/fir4_mac.sv
module fir4_mac
  import fir_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic [DATA_W-1:0]             sampleIn,
  input  logic [4*COEF_W-1:0]           coefIn,
  output logic                          done,
  output logic                          outValid,
  output logic [DATA_W+COEF_W+2-1:0]    result
);
  ctrl_t ctrl;
  logic  validInt;

  fir_ctrl ctrl_i (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .ctrl  (ctrl)
  );

  fir_datapath #(.DATA_W(DATA_W), .COEF_W(COEF_W)) dp_i (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .sampleIn (sampleIn),
    .coefIn   (coefIn),
    .outValid (validInt),
    .result   (result)
  );

  assign done     = validInt;
  assign outValid = validInt;

  AST_DONE_MATCH: assert property (@(posedge clk) disable iff (rst)
    done == outValid); // R9
endmodule

// File: tb/fir4_mac_tb_top.sv
module fir4_mac_tb_top;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam int AW = DW + CW + 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [DW-1:0] sampleIn = '0;
  logic [4*CW-1:0] coefIn = '0;
  logic          done, outValid;
  logic [AW-1:0] result;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int p1 = 0, p2 = 0, p3 = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fir4_mac #(.DATA_W(DW), .COEF_W(CW)) dut_i (
    .clk(clk), .rst(rst), .start(start), .sampleIn(sampleIn),
    .coefIn(coefIn), .done(done), .outValid(outValid), .result(result)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int coefAt(input logic [4*CW-1:0] c, input int i);
    return int'($signed(c[i*CW +: CW]));
  endfunction

  function automatic logic [4*CW-1:0] coefSet(input int k);
    case (k)
      0:       return {8'sd4, 8'sd3, 8'sd2, 8'sd1};
      1:       return {8'sd0, -8'sd1, 8'sd127, -8'sd128};
      2:       return {8'sd127, 8'sd127, 8'sd127, 8'sd127};
      default: return {8'sd100, -8'sd55, 8'sd19, -8'sd7};
    endcase
  endfunction

  // One call: start accepted at edge k, done expected after edge k+6.
  task automatic doCall(input int x, input logic [4*CW-1:0] c, input bit poke);
    int exp;
    exp = x*coefAt(c,0) + p1*coefAt(c,1) + p2*coefAt(c,2) + p3*coefAt(c,3);
    @(negedge clk);
    sampleIn = DW'(x);
    coefIn   = c;
    start    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int n = 1; n <= 6; n++) begin
      if (poke && (n == 2 || n == 4)) start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      if (n < 6) chk(done == 1'b0, "R2 early done", int'(done), 0);
    end
    chk(done == 1'b1, "R2 done at edge k+6", int'(done), 1);
    chk(outValid == done, "R9 valid matches done", int'(outValid), int'(done));
    chk($signed(result) == exp, "R3/R6/R8 result", int'($signed(result)), exp);
    p3 = p2; p2 = p1; p1 = x;
    @(posedge clk);
    @(negedge clk);
    chk(done == 1'b0 && outValid == 1'b0, "R2 pulse one cycle", int'(done), 0);
    if (poke) begin
      for (int n = 0; n < 3; n++) begin
        @(posedge clk);
        @(negedge clk);
        chk(done == 1'b0, "R5 busy start gave extra done", int'(done), 0);
      end
    end
    chk($signed(result) == exp, "R7 result held", int'($signed(result)), exp);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(done == 1'b0 && outValid == 1'b0, "R1 reset strobes", int'(done), 0);
    chk(result == '0, "R1 reset result", int'(result), 0);
    rst = 1'b0;
    // R1: first call after reset sees an all-zero delay line.
    doCall(-77, coefSet(3), 1'b0);
    // R3/R6 sweeps over coefficient sets, R5 pokes on alternate calls.
    for (int k = 0; k < 4; k++) begin
      for (int x = -128; x < 128; x += 9) begin
        doCall(x, coefSet(k), (x % 2) != 0);
      end
    end
    // R4: long idle gaps between calls.
    for (int g = 0; g < 4; g++) begin
      repeat (20 + g*7) @(posedge clk);
      doCall(g*31 - 50, coefSet(3), 1'b0);
    end
    // R8: most negative samples and coefficients.
    for (int i = 0; i < 4; i++) doCall(-128, {4{8'h80}}, 1'b0);
    chk($signed(result) == 65536, "R8 extreme sum", int'($signed(result)), 65536);
    for (int i = 0; i < 4; i++) doCall(127, {8'sd127, -8'sd128, 8'sd127, -8'sd128}, 1'b0);
    // R1: reset mid-stream clears the line again.
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk); rst = 1'b0;
    chk(result == '0, "R1 reset clears result", int'(result), 0);
    p1 = 0; p2 = 0; p3 = 0;
    doCall(55, coefSet(0), 1'b0);
    chk($signed(result) == 55, "R1 line cleared", int'($signed(result)), 55);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule